// File: doc/BRIEF.md
# Full-Speed Packet Boundary Detector

This block sits in a full-speed serial receive path, after the line state has been NRZI-decoded and in parallel with bit-unstuffing. It sees each decoded bit together with a flag that marks a single-ended-zero line state. The bus idles in J, which decodes to a steady run of ones. A packet opens with a sync field that decodes to seven zeros followed by a one. The block looks for that pattern and then holds a level high for the body of the packet. It ends the packet on the first SE0 and does not wait for the rest of the end-of-packet sequence.

A bit counts only on a clock where the valid qualifier is high. Clocks with valid low are stalls and leave all history untouched. All three outputs are registered, so each one answers the bit accepted on the previous clock. The start and end pulses last one clock each. Later stages use the start pulse to reset their PID, CRC and byte-assembly state, and the end pulse to close the packet.

Top module: `rx_pkt_detect`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on the first clock after it is released, `pkt_start`, `pkt_active` and `pkt_end` are all 0.
- R2: With no packet active, the valid non-SE0 bit that completes the decoded sync (the last eight such bits, oldest first, equal 0,0,0,0,0,0,0,1) makes `pkt_start` 1 for exactly one clock. That clock is the one after the edge on which the final bit was accepted, and `pkt_active` rises in the same clock.
- R3: Once a packet is active, `pkt_active` stays 1 whatever data bits arrive, including a further sync pattern, and no new `pkt_start` is produced until the packet has ended.
- R4: While a packet is active, the first valid bit that has `bit_se0` = 1 makes `pkt_end` 1 for one clock in the following clock, and `pkt_active` falls in that same clock.
- R5: A valid SE0 with no packet active has no effect. No end pulse appears, `pkt_active` stays 0, and the sync history is left unchanged.
- R6: Clocks with `bit_valid` = 0 are ignored. Data and SE0 on those clocks have no effect, and stalls between sync bits do not break the match.
- R7: A ones-to-one pattern with fewer than seven zeros before the one, such as a short idle glitch, does not start a packet.
- R8: A run of more than seven zeros followed by a one starts a packet, because only the last eight bits are compared.
- R9: When a packet ends, the sync history is cleared to the idle value (all ones). Zeros received during the packet therefore cannot combine with bits received after it to form a sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock domain |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies `bit_data` and `bit_se0` for this clock |
| bit_data | input | 1 | Decoded (NRZI removed) data bit |
| bit_se0 | input | 1 | Line is in single-ended zero |
| pkt_start | output | 1 | One-clock pulse after the final sync bit |
| pkt_active | output | 1 | High for the packet body |
| pkt_end | output | 1 | One-clock pulse after the first SE0 of a packet |

## Verification
A corrupted history register shows up as a start pulse that is missing or spurious one clock after the bit that should, or should not, have completed the sync. Errors of this kind are caught by stressing stalls, SE0s outside packets and long zero runs. A state register stuck busy or stuck idle shows within one clock as `pkt_active` disagreeing with the model, or as an end pulse that is missing or spurious after an SE0. A history register that is not cleared at packet end shows only later, as a start pulse after a packet tail of zeros followed by a one. The bench drives that case on purpose.

// File: rtl/rx_pkt_detect_pkg.sv
package rx_pkt_detect_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} pkt_state_t;
endpackage

// File: rtl/rx_sync_matcher.sv
module rx_sync_matcher #(
  parameter int SYNC_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_bit,
  input  logic bit_data,
  input  logic clear_hist,
  output logic sync_hit
);
  localparam int HW = SYNC_LEN - 1;

  function automatic logic is_sync(input logic [SYNC_LEN-1:0] w);
    return w == {{(SYNC_LEN-1){1'b0}}, 1'b1};
  endfunction

  logic [HW-1:0] hist_q;
  logic [SYNC_LEN-1:0] cand;

  assign cand     = {hist_q, bit_data};
  assign sync_hit = take_bit && is_sync(cand);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_hist) begin
      hist_q <= '1;
    end else if (take_bit) begin
      hist_q <= cand[HW-1:0];
    end
  end
endmodule

// File: rtl/rx_pkt_tracker.sv
module rx_pkt_tracker
  import rx_pkt_detect_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_hit,
  input  logic eop_evt,
  output logic busy,
  output logic start_q,
  output logic end_q
);
  pkt_state_t st_q;

  assign busy = (st_q == ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      start_q <= sync_hit;
      end_q   <= eop_evt;
      if (sync_hit)     st_q <= ST_BUSY;
      else if (eop_evt) st_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/rx_pkt_detect.sv
module rx_pkt_detect #(
  parameter int SYNC_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic bit_se0,
  output logic pkt_start,
  output logic pkt_active,
  output logic pkt_end
);
  logic busy_w;
  logic take_bit_w;
  logic sync_hit_w;
  logic eop_evt_w;

  // history advances only on valid data bits outside a packet
  assign take_bit_w = bit_valid && !bit_se0 && !busy_w;
  assign eop_evt_w  = bit_valid && bit_se0 && busy_w;

  rx_sync_matcher #(.SYNC_LEN(SYNC_LEN)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_bit  (take_bit_w),
    .bit_data  (bit_data),
    .clear_hist(eop_evt_w),
    .sync_hit  (sync_hit_w)
  );

  rx_pkt_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_hit(sync_hit_w),
    .eop_evt (eop_evt_w),
    .busy    (busy_w),
    .start_q (pkt_start),
    .end_q   (pkt_end)
  );

  assign pkt_active = busy_w;
endmodule

// File: rtl/rx_pkt_detect_chk.sv
module rx_pkt_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic bit_se0,
  input logic pkt_start,
  input logic pkt_active,
  input logic pkt_end
);
  a_r2_start_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start);
  a_r2_start_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> pkt_active);
  a_r3_no_start_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active && !pkt_start) |=> !pkt_start);
  a_r4_end_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (!pkt_active && !pkt_start));
  a_r5_idle_se0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_active && bit_valid && bit_se0) |=> (!pkt_end && !pkt_active));
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!pkt_start && !pkt_end && $stable(pkt_active)));
  a_r4_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_start, pkt_end}));
endmodule

bind rx_pkt_detect rx_pkt_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .bit_se0   (bit_se0),
  .pkt_start (pkt_start),
  .pkt_active(pkt_active),
  .pkt_end   (pkt_end)
);

// File: tb/rx_pkt_detect_bench.sv
module rx_pkt_detect_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_valid, bit_data, bit_se0;
  logic pkt_start, pkt_active, pkt_end;

  int checks = 0;
  int errors = 0;

  // bench model: count of zeros since the last one (saturating)
  int  zrun;
  logic m_act, m_start, m_end;

  always #2.5 clk = ~clk;

  rx_pkt_detect u_rx_pkt_detect (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_se0(bit_se0), .pkt_start(pkt_start), .pkt_active(pkt_active),
    .pkt_end(pkt_end)
  );

  function automatic logic sync_done(input int zeros, input logic d);
    return d && (zeros >= 7);
  endfunction

  task automatic check3(input string tag);
    checks++;
    if (pkt_start !== m_start || pkt_active !== m_act || pkt_end !== m_end) begin
      errors++;
      $display("FAIL %s: got start=%b active=%b end=%b, expected start=%b active=%b end=%b",
               tag, pkt_start, pkt_active, pkt_end, m_start, m_act, m_end);
    end
  endtask

  // drive at negedge, update model, check after the next rising edge
  task automatic step(input logic v, input logic d, input logic s, input string tag);
    bit_valid = v; bit_data = d; bit_se0 = s;
    m_start = 1'b0; m_end = 1'b0;
    if (v && !s && !m_act) begin
      if (sync_done(zrun, d)) begin
        m_start = 1'b1; m_act = 1'b1; zrun = 0;
      end else if (d) zrun = 0;
      else if (zrun < 100) zrun++;
    end else if (v && s && m_act) begin
      m_end = 1'b1; m_act = 1'b0; zrun = 0;
    end
    @(posedge clk);
    @(negedge clk);
    check3(tag);
  endtask

  task automatic send_sync(input string tag, input bit stalls);
    for (int i = 0; i < 8; i++) begin
      if (stalls) step(1'b0, 1'b0, 1'b1, "R6");
      step(1'b1, (i == 7), 1'b0, tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, "R7");
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_valid = 1'b0; bit_data = 1'b0; bit_se0 = 1'b0;
    zrun = 0; m_act = 1'b0; m_start = 1'b0; m_end = 1'b0;
    repeat (3) @(negedge clk);
    check3("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check3("R1 after reset");

    idle(10);
    send_sync("R2", 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, (i == 7), 1'b0, "R3");   // sync inside packet
    step(1'b1, 1'b0, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");

    send_sync("R6", 1'b1);
    step(1'b1, 1'b0, 1'b1, "R4");

    idle(4);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    idle(3);

    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b0, 1'b0, "R5");
      if (i == 3) step(1'b1, 1'b1, 1'b1, "R5");  // SE0 idle mid-sync: history kept
    end
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b1, "R4");

    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");   // zeros of packet tail must not count
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) send_sync("R2 rand", ($urandom_range(0, 1) == 1));
      else if (r < 20) step(1'b0, 1'($urandom), 1'($urandom), "R6 rand");
      else if (r < 24) step(1'b1, 1'($urandom), 1'b1, "R4 rand");
      else if (r < 60) step(1'b1, 1'b0, 1'b0, "R8 rand");
      else step(1'b1, 1'($urandom), 1'b0, "R3 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule